// File: doc/BRIEF.md
# Render-Completion Interrupt Register Block

This block sits at the host-facing edge of a pixel pipeline and turns two pipeline events into maskable interrupt lines. A token event arrives with a 16-bit marker value and a request flag: the marker is always kept in a read-only register, and the token interrupt is flagged only when the request flag is set. A finish event, raised when a frame has been fully drawn, always flags the finish interrupt. Software enables each interrupt and acknowledges it through a single 16-bit control register, in which two bits hold the enables and two write-only bits clear the flags.

The block also presents a set of live 32-bit event counters to the host as pairs of read-only 16-bit halves. The counters themselves are built elsewhere. Reads are combinational from the register state. Writes take effect at the next rising clock edge.

Top module: `pe_irq_regs`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the control register reads 0x0000, the token register reads 0x0000, both interrupt outputs are low and both pending flags are clear.
- R2: At offset 0x00 the control register reads bit 0 as the token enable and bit 1 as the finish enable, each holding the last value written. Bits 15:2 always read as zero.
- R3: A write to offset 0x00 with bit 2 set clears the token pending flag, and one with bit 3 set clears the finish pending flag. A write with a 0 in either bit leaves that flag as it was.
- R4: The output irq_token is high exactly when the token pending flag is set and the token enable is 1. The output irq_finish follows the same rule with its own flag and enable. Both outputs are registered and change at the same clock edge that samples the write or event causing the change.
- R5: irq_cause carries irq_token on bit 9 (mask 0x200) and irq_finish on bit 10 (mask 0x400). All its other bits are zero.
- R6: A token event always loads tok_value into the token register, which is read at offset 0x02. It sets the token pending flag only when tok_ack is 1.
- R7: A finish event always sets the finish pending flag.
- R8: Counter i (0 to NUM_CNT-1) reads its bits 15:0 at offset 0x10+4*i and its bits 31:16 at offset 0x12+4*i. Writes to these offsets change nothing.
- R9: Writes to the token register at offset 0x02 are ignored.
- R10: If a clear write and a setting event for the same flag occur in the same cycle, the flag ends up set.
- R11: Reads from an unmapped offset, including odd offsets, return zero. Writes to an unmapped offset have no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current offset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| tok_evt | input | 1 | Token event strobe |
| tok_value | input | 16 | Token marker carried by the event |
| tok_ack | input | 1 | Token event requests an interrupt |
| fin_evt | input | 1 | Frame-finish event strobe |
| cnt_in | input | NUM_CNT*32 | Live counter values, counter i at bits 32*i+31:32*i |
| irq_token | output | 1 | Token interrupt line |
| irq_finish | output | 1 | Finish interrupt line |
| irq_cause | output | 16 | Interrupt cause mask |

## Verification
The bench puts a clear write and a setting event for the same flag in one cycle. A design that gave the clear priority would drop the event and leave the line low. It sends token events with the request flag low and checks that the marker still updates while the line stays quiet. A design that tied the two together would either lose the marker or raise a spurious interrupt. It writes zeros to the clear bits while a flag is pending, toggles an enable over a flag that is still pending so that the line falls and comes back, and writes to the token register, the counter offsets and unmapped or odd offsets. A decoder that aliased those offsets, or let the write-only bits read back, would show it on the read data or the lines.

// File: rtl/pe_irq_pkg.sv
// pe_irq_pkg: offsets, bit positions and cause-mask positions shared by
// the interrupt register block, its checker and its bench.
package pe_irq_pkg;
    // Register offsets (byte addresses, 16-bit aligned)
    localparam int CTRL_OFS  = 'h00;
    localparam int TOKEN_OFS = 'h02;
    localparam int CNT_BASE  = 'h10;
    localparam int CNT_STEP  = 4;

    // Control register bit positions
    localparam int EN_TOK_BIT  = 0;
    localparam int EN_FIN_BIT  = 1;
    localparam int CLR_TOK_BIT = 2;
    localparam int CLR_FIN_BIT = 3;

    // Interrupt channels
    localparam int NUM_CH = 2;
    localparam int CH_TOK = 0;
    localparam int CH_FIN = 1;

    // Cause mask bit positions
    localparam int CAUSE_TOK_BIT = 9;
    localparam int CAUSE_FIN_BIT = 10;

    localparam int REG_W = 16;
endpackage

// File: rtl/pe_irq_chan.sv
// pe_irq_chan: enable bits, pending flags and registered interrupt lines.
// Assumes the caller has already decoded a control-register write. A set
// event has priority over a clear in the same cycle.
module pe_irq_chan
    import pe_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [NUM_CH-1:0] wr_en_bits,
    input  logic [NUM_CH-1:0] wr_clr_bits,
    input  logic [NUM_CH-1:0] set_evt,
    output logic [NUM_CH-1:0] en_q,
    output logic [NUM_CH-1:0] irq_q
);
    logic [NUM_CH-1:0] pend_q;
    logic [NUM_CH-1:0] pend_nx;
    logic [NUM_CH-1:0] en_nx;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            // Next pending state: set wins, then clear, else hold
            always_comb begin
                if (set_evt[c])
                    pend_nx[c] = 1'b1;
                else if (ctrl_wr && wr_clr_bits[c])
                    pend_nx[c] = 1'b0;
                else
                    pend_nx[c] = pend_q[c];
            end

            // Next enable state: loaded on a control write
            always_comb en_nx[c] = ctrl_wr ? wr_en_bits[c] : en_q[c];

            // State registers and the gated interrupt line
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q[c] <= 1'b0;
                    en_q[c]   <= 1'b0;
                    irq_q[c]  <= 1'b0;
                end else begin
                    pend_q[c] <= pend_nx[c];
                    en_q[c]   <= en_nx[c];
                    irq_q[c]  <= pend_nx[c] & en_nx[c];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pe_token_hold.sv
// pe_token_hold: keeps the marker from the latest token event. It is
// loaded only by events and never by the host bus.
module pe_token_hold #(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_evt,
    input  logic [VAL_W-1:0] tok_value,
    output logic [VAL_W-1:0] token_q
);
    // Capture the marker on every token event
    always_ff @(posedge clk) begin
        if (!rst_n)
            token_q <= '0;
        else if (tok_evt)
            token_q <= tok_value;
    end
endmodule

// File: rtl/pe_cnt_view.sv
// pe_cnt_view: presents NUM_CNT live counters as 16-bit read halves.
// The low half sits at the counter's base offset and the high half two
// bytes above it. Offsets that match no half read as zero.
module pe_cnt_view #(
    parameter int ADDR_W  = 8,
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32,
    parameter int BASE    = 'h10,
    parameter int STEP    = 4
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NUM_CNT*CNT_W-1:0] cnt_in,
    output logic                     hit,
    output logic [CNT_W/2-1:0]       rdata
);
    localparam int HALF_W = CNT_W / 2;

    logic [NUM_CNT-1:0] hit_lo;
    logic [NUM_CNT-1:0] hit_hi;
    logic [HALF_W-1:0]  part [NUM_CNT];

    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
            localparam int LO_OFS = BASE + STEP * i;
            localparam int HI_OFS = LO_OFS + 2;
            // Match this counter's two halves
            always_comb begin
                hit_lo[i] = (addr == ADDR_W'(LO_OFS));
                hit_hi[i] = (addr == ADDR_W'(HI_OFS));
            end
            // Select the half that matched, else zero
            always_comb begin
                if (hit_lo[i])
                    part[i] = cnt_in[CNT_W*i +: HALF_W];
                else if (hit_hi[i])
                    part[i] = cnt_in[CNT_W*i + HALF_W +: HALF_W];
                else
                    part[i] = '0;
            end
        end
    endgenerate

    // Merge the per-counter selections
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CNT; i++)
            rdata = rdata | part[i];
        hit = |{hit_lo, hit_hi};
    end
endmodule

// File: rtl/pe_irq_regs.sv
// pe_irq_regs: register block for the token and finish interrupts. It has
// 16-bit host access with combinational reads and writes at the clock edge.
// It assumes the host gives one access per cycle and that event strobes
// last one cycle per event.
module pe_irq_regs
    import pe_irq_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [15:0]              bus_wdata,
    output logic [15:0]              bus_rdata,
    input  logic                     tok_evt,
    input  logic [15:0]              tok_value,
    input  logic                     tok_ack,
    input  logic                     fin_evt,
    input  logic [NUM_CNT*CNT_W-1:0] cnt_in,
    output logic                     irq_token,
    output logic                     irq_finish,
    output logic [15:0]              irq_cause
);
    logic              sel_ctrl;
    logic              sel_token;
    logic              ctrl_wr;
    logic [NUM_CH-1:0] wr_en_bits;
    logic [NUM_CH-1:0] wr_clr_bits;
    logic [NUM_CH-1:0] set_evt;
    logic [NUM_CH-1:0] ctrl_en;
    logic [NUM_CH-1:0] irq_q;
    logic [15:0]       token_q;
    logic              cnt_hit;
    logic [15:0]       cnt_rdata;
    logic              unused_wdata_hi;

    // Offset decode for the directly held registers
    always_comb begin
        sel_ctrl  = (bus_addr == ADDR_W'(CTRL_OFS));
        sel_token = (bus_addr == ADDR_W'(TOKEN_OFS));
        ctrl_wr   = bus_wr && sel_ctrl;
    end

    // Split the control write data and the events into channels
    always_comb begin
        wr_en_bits[CH_TOK]  = bus_wdata[EN_TOK_BIT];
        wr_en_bits[CH_FIN]  = bus_wdata[EN_FIN_BIT];
        wr_clr_bits[CH_TOK] = bus_wdata[CLR_TOK_BIT];
        wr_clr_bits[CH_FIN] = bus_wdata[CLR_FIN_BIT];
        set_evt[CH_TOK]     = tok_evt && tok_ack;
        set_evt[CH_FIN]     = fin_evt;
    end

    assign unused_wdata_hi = ^bus_wdata[15:4];

    pe_irq_chan u_chan (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .wr_en_bits  (wr_en_bits),
        .wr_clr_bits (wr_clr_bits),
        .set_evt     (set_evt),
        .en_q        (ctrl_en),
        .irq_q       (irq_q)
    );

    pe_token_hold #(.VAL_W(16)) u_token (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_evt   (tok_evt),
        .tok_value (tok_value),
        .token_q   (token_q)
    );

    pe_cnt_view #(
        .ADDR_W  (ADDR_W),
        .NUM_CNT (NUM_CNT),
        .CNT_W   (CNT_W),
        .BASE    (CNT_BASE),
        .STEP    (CNT_STEP)
    ) u_cnt (
        .addr   (bus_addr),
        .cnt_in (cnt_in),
        .hit    (cnt_hit),
        .rdata  (cnt_rdata)
    );

    // Read multiplexer; unmapped offsets return zero
    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata[EN_TOK_BIT] = ctrl_en[CH_TOK];
            bus_rdata[EN_FIN_BIT] = ctrl_en[CH_FIN];
        end else if (sel_token) begin
            bus_rdata = token_q;
        end else if (cnt_hit) begin
            bus_rdata = cnt_rdata;
        end
    end

    // Interrupt lines and the cause mask
    always_comb begin
        irq_token                = irq_q[CH_TOK];
        irq_finish               = irq_q[CH_FIN];
        irq_cause                = '0;
        irq_cause[CAUSE_TOK_BIT] = irq_q[CH_TOK];
        irq_cause[CAUSE_FIN_BIT] = irq_q[CH_FIN];
    end
endmodule

// File: rtl/pe_irq_regs_chk.sv
// pe_irq_regs_chk: temporal checks on the interrupt register block,
// attached to every instance of the top module by the bind below.
module pe_irq_regs_chk
    import pe_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic              tok_evt,
    input logic              tok_ack,
    input logic              fin_evt,
    input logic              irq_token,
    input logic              irq_finish,
    input logic [15:0]       irq_cause,
    input logic [15:0]       token_q,
    input logic [1:0]        ctrl_en
);
    logic ctrl_access;
    assign ctrl_access = (bus_addr == ADDR_W'(CTRL_OFS));

    assert_ctrl_hi_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_access |-> (bus_rdata[15:2] == 14'd0));

    assert_tok_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ctrl_access && bus_wdata[CLR_TOK_BIT] && !(tok_evt && tok_ack))
        |=> !irq_token);

    assert_fin_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ctrl_access && bus_wdata[CLR_FIN_BIT] && !fin_evt)
        |=> !irq_finish);

    assert_tok_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en[CH_TOK] |-> !irq_token);

    assert_fin_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en[CH_FIN] |-> !irq_finish);

    assert_cause_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_cause[CAUSE_TOK_BIT] == irq_token) && (irq_cause[CAUSE_FIN_BIT] == irq_finish)
        && ($countones(irq_cause) == $countones({irq_token, irq_finish})));

    assert_tok_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_evt && tok_ack && ctrl_en[CH_TOK] && !bus_wr) |=> irq_token);

    assert_tok_noack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_evt && !tok_ack && !bus_wr && ctrl_en[CH_TOK] && !irq_token) |=> !irq_token);

    assert_fin_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_evt && ctrl_en[CH_FIN] && !bus_wr) |=> irq_finish);

    assert_token_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_evt |=> $stable(token_q));

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ctrl_access && bus_wdata[CLR_TOK_BIT] && bus_wdata[EN_TOK_BIT]
         && tok_evt && tok_ack) |=> irq_token);
endmodule

bind pe_irq_regs pe_irq_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .tok_evt    (tok_evt),
    .tok_ack    (tok_ack),
    .fin_evt    (fin_evt),
    .irq_token  (irq_token),
    .irq_finish (irq_finish),
    .irq_cause  (irq_cause),
    .token_q    (token_q),
    .ctrl_en    (ctrl_en)
);

// File: tb/pe_irq_regs_tb.sv
// Bench for pe_irq_regs: directed corner cases followed by seeded random
// traffic, all compared against a reference model kept in the bench.
module pe_irq_regs_tb_top;
    localparam int ADDR_W  = 8;
    localparam int NUM_CNT = 4;
    localparam int CNT_W   = 32;

    logic                     clk = 1'b0;
    logic                     rst_n;
    logic                     bus_wr;
    logic [ADDR_W-1:0]        bus_addr;
    logic [15:0]              bus_wdata;
    logic [15:0]              bus_rdata;
    logic                     tok_evt;
    logic [15:0]              tok_value;
    logic                     tok_ack;
    logic                     fin_evt;
    logic [NUM_CNT*CNT_W-1:0] cnt_in;
    logic                     irq_token;
    logic                     irq_finish;
    logic [15:0]              irq_cause;

    int checks   = 0;
    int failures = 0;

    // Reference model state
    logic [1:0]  m_en;
    logic        m_ptok;
    logic        m_pfin;
    logic [15:0] m_token;

    always #5 clk = ~clk;

    pe_irq_regs #(.ADDR_W(ADDR_W), .NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .tok_evt    (tok_evt),
        .tok_value  (tok_value),
        .tok_ack    (tok_ack),
        .fin_evt    (fin_evt),
        .cnt_in     (cnt_in),
        .irq_token  (irq_token),
        .irq_finish (irq_finish),
        .irq_cause  (irq_cause)
    );

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    // Expected read data for an offset
    function automatic logic [15:0] exp_read(input logic [ADDR_W-1:0] a);
        int idx;
        if (a == 8'h00) return {14'd0, m_en};
        if (a == 8'h02) return m_token;
        if (a >= 8'h10 && a < 8'h10 + 4 * NUM_CNT && a[0] == 1'b0) begin
            idx = (int'(a) - 'h10) / 4;
            return a[1] ? cnt_in[CNT_W*idx + 16 +: 16] : cnt_in[CNT_W*idx +: 16];
        end
        return 16'h0000;
    endfunction

    // One clocked cycle: drive, update the model at the edge, check the lines
    task automatic cycle(input logic wr, input logic [ADDR_W-1:0] a, input logic [15:0] wd,
                         input logic te, input logic [15:0] tv, input logic ta, input logic fe,
                         input string tag);
        bus_wr = wr; bus_addr = a; bus_wdata = wd;
        tok_evt = te; tok_value = tv; tok_ack = ta; fin_evt = fe;
        @(posedge clk);
        if (te && ta) m_ptok = 1'b1;
        else if (wr && a == 8'h00 && wd[2]) m_ptok = 1'b0;
        if (fe) m_pfin = 1'b1;
        else if (wr && a == 8'h00 && wd[3]) m_pfin = 1'b0;
        if (wr && a == 8'h00) m_en = wd[1:0];
        if (te) m_token = tv;
        #1;
        check16({tag, " R4 irq lines"}, {14'd0, irq_finish, irq_token},
                {14'd0, m_pfin & m_en[1], m_ptok & m_en[0]});
        check16({tag, " R5 cause"}, irq_cause,
                16'(((m_ptok & m_en[0]) ? 'h200 : 0) | ((m_pfin & m_en[1]) ? 'h400 : 0)));
        bus_wr = 1'b0; tok_evt = 1'b0; fin_evt = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        check16(tag, bus_rdata, exp_read(a));
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5EED_1234);
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        tok_evt = 1'b0; tok_value = '0; tok_ack = 1'b0; fin_evt = 1'b0;
        cnt_in = '0;
        for (int i = 0; i < NUM_CNT; i++) cnt_in[CNT_W*i +: CNT_W] = $urandom;
        m_en = '0; m_ptok = 1'b0; m_pfin = 1'b0; m_token = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h00, "R1 ctrl after reset");
        rd(8'h02, "R1 token after reset");
        check16("R1 irq after reset", {14'd0, irq_finish, irq_token}, 16'd0);

        // R2: enables read back, write-only bits read zero
        cycle(1'b1, 8'h00, 16'hFFFF, 0, 0, 0, 0, "R2 all-ones write");
        rd(8'h00, "R2 ctrl readback 0x3");
        cycle(1'b1, 8'h00, 16'h0002, 0, 0, 0, 0, "R2 finish only");
        rd(8'h00, "R2 ctrl readback 0x2");

        // R6: token without ack latches value, no interrupt
        cycle(1'b1, 8'h00, 16'h0003, 0, 0, 0, 0, "R6 enable both");
        cycle(1'b0, 8'h00, 16'h0, 1, 16'hBEEF, 0, 0, "R6 token noack");
        rd(8'h02, "R6 token value noack");
        cycle(1'b0, 8'h00, 16'h0, 1, 16'h1234, 1, 0, "R6 token ack");
        rd(8'h02, "R6 token value ack");

        // R3: zero in clear bits keeps flags; R7 finish sets
        cycle(1'b0, 8'h00, 16'h0, 0, 0, 0, 1, "R7 finish event");
        cycle(1'b1, 8'h00, 16'h0003, 0, 0, 0, 0, "R3 zero clear bits");
        // R4: disabling hides a pending flag, re-enabling shows it
        cycle(1'b1, 8'h00, 16'h0000, 0, 0, 0, 0, "R4 disable both");
        cycle(1'b1, 8'h00, 16'h0003, 0, 0, 0, 0, "R4 re-enable both");
        cycle(1'b1, 8'h00, 16'h0007, 0, 0, 0, 0, "R3 clear token");
        cycle(1'b1, 8'h00, 16'h000B, 0, 0, 0, 0, "R3 clear finish");

        // R10: set wins over clear in the same cycle
        cycle(1'b1, 8'h00, 16'h000F, 1, 16'h0042, 1, 1, "R10 set beats clear");

        // R9: token register ignores writes
        cycle(1'b1, 8'h02, 16'hDEAD, 0, 0, 0, 0, "R9 token write");
        rd(8'h02, "R9 token unchanged");

        // R8: counter halves, writes ignored
        for (int i = 0; i < NUM_CNT; i++) begin
            cycle(1'b1, 8'(8'h10 + 4 * i), 16'hFFFF, 0, 0, 0, 0, "R8 counter write");
            rd(8'(8'h10 + 4 * i), "R8 counter low half");
            rd(8'(8'h12 + 4 * i), "R8 counter high half");
        end

        // R11: unmapped and odd offsets
        cycle(1'b1, 8'h01, 16'h0004, 0, 0, 0, 0, "R11 odd write");
        cycle(1'b1, 8'h40, 16'h000C, 0, 0, 0, 0, "R11 unmapped write");
        rd(8'h01, "R11 odd read");
        rd(8'h06, "R11 gap read");
        rd(8'hFE, "R11 high read");
        rd(8'h00, "R11 ctrl unchanged");

        // Random traffic across all requirements
        for (int n = 0; n < 1500; n++) begin
            logic [ADDR_W-1:0] a;
            logic [15:0] wd;
            int pick;
            pick = $urandom_range(0, 9);
            if (pick < 5) a = 8'h00;
            else if (pick < 6) a = 8'h02;
            else if (pick < 8) a = 8'(8'h10 + 2 * $urandom_range(0, 2 * NUM_CNT - 1));
            else a = 8'($urandom);
            wd = 16'($urandom);
            if ((n % 97) == 0)
                for (int i = 0; i < NUM_CNT; i++) cnt_in[CNT_W*i +: CNT_W] = $urandom;
            cycle(1'($urandom_range(0, 1)), a, wd,
                  ($urandom_range(0, 3) == 0), 16'($urandom), 1'($urandom),
                  ($urandom_range(0, 4) == 0), "R10 R3 R6 R7 random");
            rd(8'($urandom_range(0, 3) == 0 ? $urandom : 2 * $urandom_range(0, 15)),
               "R2 R8 R11 random read");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: counts as a failure and still reports
    initial begin
        #1500000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule